// File: doc/BRIEF.md
# PWM Compare Blanking Window Generator

This block produces a blanking signal that masks digital-compare trip events for a programmed stretch of every PWM period. A 16-bit offset counter is armed by a pulse from the time base. A select bit picks which pulse arms it: the period-match pulse or the counter-zero pulse. The counter then counts down once per time-base tick. On the tick where it reaches zero, an 8-bit window counter loads the programmed width and counts down, and the blanking output stays high while that counter is non-zero.

The window does not stop at a period boundary. An arming pulse that arrives while a window is open leaves the window running. If the offset counter expires again while a window is open, the window reloads to its full width. Both live counts are brought out so that they can be read. A debug halt input is accepted and ignored, so the offset countdown carries on while the device is halted. There is no streaming data path here: every pin is a plain control or status level, sampled on the rising clock edge.

Top module: `blank_win_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `offset_cnt_o` and `window_cnt_o` to 0 and drives `blank_o` low on the next edge.
- R2: Both counters change only on clock edges where `tb_tick` is 1. Arming pulses that arrive on cycles with `tb_tick` = 0 are ignored.
- R3: With `sel_zero` = 0 the offset counter is armed by `prd_pulse`. With `sel_zero` = 1 it is armed by `zro_pulse`. The pulse that is not selected has no effect.
- R4: On a tick with the selected pulse high, `offset_cnt_o` takes `offset_val`. On a tick without the pulse, it decrements by one while non-zero and holds at 0 once it gets there.
- R5: Expiry occurs on the tick where the offset count steps from 1 to 0, or on an arming tick with `offset_val` = 0. On that tick `window_cnt_o` loads `win_width`, and `blank_o` is high from the next cycle.
- R6: With `win_width` = W in 1..255 and no further expiry, `blank_o` stays high for exactly W ticks. `window_cnt_o` counts W, W-1, ..., 1 and then reaches 0.
- R7: A `win_width` of 0 produces no blanking: `blank_o` stays low after the expiry.
- R8: An expiry while a window is open reloads `window_cnt_o` to the full `win_width`.
- R9: An arming pulse does not end or shorten an open window, so the window can run across a PWM period boundary.
- R10: `halt` has no effect on either counter or on `blank_o`.
- R11: `blank_o` is 1 exactly when `window_cnt_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_tick | input | 1 | Time-base clock enable |
| prd_pulse | input | 1 | Period-match pulse from the time base |
| zro_pulse | input | 1 | Counter-zero pulse from the time base |
| sel_zero | input | 1 | Arming source: 0 = period pulse, 1 = zero pulse |
| offset_val | input | 16 | Programmed offset, in ticks |
| win_width | input | 8 | Programmed window width, in ticks; 0 disables blanking |
| halt | input | 1 | Debug halt request (ignored) |
| blank_o | output | 1 | Blanking window active |
| offset_cnt_o | output | 16 | Live offset counter value |
| window_cnt_o | output | 8 | Live window counter value |

## Verification
The properties assume that the inputs change only away from the rising edge and that the programmed values are stable for the whole clock cycle in which they are sampled. They place no limit on how the pulses, the tick or the halt input are combined, so the checker is also valid when both pulses fire together or when a pulse falls on a cycle without a tick. The stimulus drives every input once per cycle on the falling edge. It walks through directed sequences for each requirement and then a pseudo-random stretch in which pulses, ticks and halt toggle freely.

// File: rtl/blank_win_pkg.sv
package blank_win_pkg;
  localparam int OFF_W = 16;
  localparam int WIN_W = 8;

  typedef enum logic {
    ARM_ON_PERIOD = 1'b0,
    ARM_ON_ZERO   = 1'b1
  } arm_src_e;
endpackage

// File: rtl/bw_arm_sel.sv
module bw_arm_sel
  import blank_win_pkg::*;
(
  input  logic     tick,
  input  logic     prd_pulse,
  input  logic     zro_pulse,
  input  arm_src_e src,
  output logic     arm
);
  logic picked;

  always_comb begin
    unique case (src)
      ARM_ON_ZERO:   picked = zro_pulse;
      default:       picked = prd_pulse;
    endcase
  end

  // pulses only count on time-base ticks
  assign arm = picked & tick;
endmodule

// File: rtl/bw_down_ctr.sv
module bw_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (tick) begin
      if (load) begin
        cnt_d = load_val;
        hit   = (load_val == ZERO);
      end else if (cnt_q != ZERO) begin
        cnt_d = cnt_q - ONE;
        hit   = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/blank_win_gen.sv
module blank_win_gen
  import blank_win_pkg::*;
#(
  parameter int OFFSET_W = OFF_W,
  parameter int WIDTH_W  = WIN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tb_tick,
  input  logic                prd_pulse,
  input  logic                zro_pulse,
  input  logic                sel_zero,
  input  logic [OFFSET_W-1:0] offset_val,
  input  logic [WIDTH_W-1:0]  win_width,
  input  logic                halt,
  output logic                blank_o,
  output logic [OFFSET_W-1:0] offset_cnt_o,
  output logic [WIDTH_W-1:0]  window_cnt_o
);
  localparam logic [WIDTH_W-1:0] WIN_IDLE = '0;

  arm_src_e arm_src;
  logic     arm;
  logic     off_expire;
  logic     off_hit_unused_w;
  logic     unused_halt;

  // the halt request is deliberately not wired into either counter
  assign unused_halt = halt;
  assign arm_src     = arm_src_e'(sel_zero);

  bw_arm_sel u_arm (
    .tick      (tb_tick),
    .prd_pulse (prd_pulse),
    .zro_pulse (zro_pulse),
    .src       (arm_src),
    .arm       (arm)
  );

  bw_down_ctr #(.W(OFFSET_W)) u_offset (
    .clk      (clk),
    .rst      (rst),
    .tick     (tb_tick),
    .load     (arm),
    .load_val (offset_val),
    .cnt      (offset_cnt_o),
    .hit      (off_expire)
  );

  // expiry restarts the window at full width, even when it is already open
  bw_down_ctr #(.W(WIDTH_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .tick     (tb_tick),
    .load     (off_expire),
    .load_val (win_width),
    .cnt      (window_cnt_o),
    .hit      (off_hit_unused_w)
  );

  assign blank_o = (window_cnt_o != WIN_IDLE);
endmodule

// File: rtl/blank_win_gen_chk.sv
module blank_win_gen_chk #(
  parameter int OFFSET_W = 16,
  parameter int WIDTH_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                tb_tick,
  input logic                prd_pulse,
  input logic                zro_pulse,
  input logic                sel_zero,
  input logic [OFFSET_W-1:0] offset_val,
  input logic [WIDTH_W-1:0]  win_width,
  input logic                blank_o,
  input logic [OFFSET_W-1:0] offset_cnt_o,
  input logic [WIDTH_W-1:0]  window_cnt_o
);
  logic arm_seen;
  logic exp_seen;
  assign arm_seen = tb_tick && (sel_zero ? zro_pulse : prd_pulse);
  assign exp_seen = arm_seen ? (offset_val == '0) : (tb_tick && offset_cnt_o == 1);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tb_tick |=> ($stable(offset_cnt_o) && $stable(window_cnt_o)));

  // R4
  off_load_chk: assert property (@(posedge clk) disable iff (rst)
    arm_seen |=> offset_cnt_o == $past(offset_val));

  // R4
  off_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (tb_tick && !arm_seen && offset_cnt_o != 0) |=> offset_cnt_o == $past(offset_cnt_o) - 1'b1);

  // R4
  off_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (tb_tick && !arm_seen && offset_cnt_o == 0) |=> offset_cnt_o == 0);

  // R5
  win_start_chk: assert property (@(posedge clk) disable iff (rst)
    exp_seen |=> window_cnt_o == $past(win_width));

  // R6
  win_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (tb_tick && !exp_seen && window_cnt_o != 0) |=> window_cnt_o == $past(window_cnt_o) - 1'b1);

  // R11
  blank_match_chk: assert property (@(posedge clk) disable iff (rst)
    blank_o == (window_cnt_o != 0));
endmodule

bind blank_win_gen blank_win_gen_chk #(.OFFSET_W(OFFSET_W), .WIDTH_W(WIDTH_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .tb_tick      (tb_tick),
  .prd_pulse    (prd_pulse),
  .zro_pulse    (zro_pulse),
  .sel_zero     (sel_zero),
  .offset_val   (offset_val),
  .win_width    (win_width),
  .blank_o      (blank_o),
  .offset_cnt_o (offset_cnt_o),
  .window_cnt_o (window_cnt_o)
);

// File: tb/blank_win_gen_tb_top.sv
`timescale 1ns/1ps
module blank_win_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tb_tick = 1'b0;
  logic        prd_pulse = 1'b0;
  logic        zro_pulse = 1'b0;
  logic        sel_zero = 1'b0;
  logic [15:0] offset_val = '0;
  logic [7:0]  win_width = '0;
  logic        halt = 1'b0;
  logic        blank_o;
  logic [15:0] offset_cnt_o;
  logic [7:0]  window_cnt_o;

  always #10 clk = ~clk;

  blank_win_gen dut_i (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .prd_pulse(prd_pulse),
    .zro_pulse(zro_pulse), .sel_zero(sel_zero), .offset_val(offset_val),
    .win_width(win_width), .halt(halt), .blank_o(blank_o),
    .offset_cnt_o(offset_cnt_o), .window_cnt_o(window_cnt_o)
  );

  typedef struct {
    logic [15:0] off;
    logic [7:0]  win;
    logic        blk;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;
  logic [15:0] m_off   = '0;
  logic [7:0]  m_win   = '0;

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(input logic r, input logic tk, input logic pp, input logic zp,
                      input logic sz, input logic [15:0] ov, input logic [7:0] w,
                      input logic h, input string tag);
    logic arm_v, exp_v;
    logic [15:0] n_off;
    logic [7:0]  n_win;
    exp_t e;
    @(negedge clk);
    rst = r; tb_tick = tk; prd_pulse = pp; zro_pulse = zp;
    sel_zero = sz; offset_val = ov; win_width = w; halt = h;
    n_off = m_off; n_win = m_win; exp_v = 1'b0;
    if (r) begin
      n_off = '0; n_win = '0;
    end else if (tk) begin
      arm_v = sz ? zp : pp;
      if (arm_v) begin n_off = ov; exp_v = (ov == 0); end
      else if (m_off != 0) begin n_off = m_off - 1; exp_v = (m_off == 1); end
      if (exp_v) n_win = w;
      else if (m_win != 0) n_win = m_win - 1;
    end
    m_off = n_off; m_win = n_win;
    e.off = n_off; e.win = n_win; e.blk = (n_win != 0); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (offset_cnt_o !== e.off || window_cnt_o !== e.win || blank_o !== e.blk) begin
          n_fail++;
          $display("FAIL %s: off=%0d win=%0d blank=%0b expected off=%0d win=%0d blank=%0b",
                   e.tag, offset_cnt_o, window_cnt_o, blank_o, e.off, e.win, e.blk);
        end
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1 reset state
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 1, 0, 0, 16'd5, 8'd3, 0, "R1");
    // R4 R5 R6 R11: arm via period, offset 3, width 4
    step(0, 1, 1, 0, 0, 16'd3, 8'd4, 0, "R4");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, 16'd3, 8'd4, 0, "R6");
    // R2: pulses without tick ignored, counters frozen
    step(0, 1, 1, 0, 0, 16'd2, 8'd3, 0, "R2");
    step(0, 0, 1, 0, 0, 16'd9, 8'd3, 0, "R2");
    step(0, 0, 0, 0, 0, 16'd9, 8'd3, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 16'd9, 8'd3, 0, "R2");
    step(0, 0, 0, 0, 0, 16'd9, 8'd3, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 16'd9, 8'd3, 0, "R5");
    // R3: zero select, period pulse ignored
    step(0, 1, 1, 0, 1, 16'd7, 8'd2, 0, "R3");
    step(0, 1, 0, 1, 1, 16'd2, 8'd2, 0, "R3");
    step(0, 1, 1, 0, 1, 16'd8, 8'd2, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 16'd8, 8'd2, 0, "R3");
    // R7: width zero
    step(0, 1, 1, 0, 0, 16'd1, 8'd0, 0, "R7");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 16'd1, 8'd0, 0, "R7");
    // R5: arm with offset zero expires at once
    step(0, 1, 1, 0, 0, 16'd0, 8'd3, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 16'd0, 8'd3, 0, "R5");
    // R8: retrigger while open
    step(0, 1, 1, 0, 0, 16'd1, 8'd6, 0, "R8");
    step(0, 1, 0, 0, 0, 16'd1, 8'd6, 0, "R8");
    step(0, 1, 0, 0, 0, 16'd1, 8'd6, 0, "R8");
    step(0, 1, 1, 0, 0, 16'd1, 8'd6, 0, "R8");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 0, 16'd1, 8'd6, 0, "R8");
    // R9: window spans arming pulses
    step(0, 1, 1, 0, 0, 16'd0, 8'd12, 0, "R9");
    for (int i = 0; i < 14; i++)
      step(0, 1, (i % 4) == 3, 0, 0, 16'd20, 8'd12, 0, "R9");
    // R10: halt toggling has no effect
    step(0, 1, 1, 0, 0, 16'd3, 8'd5, 1, "R10");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, 16'd3, 8'd5, i[0], "R10");
    // R4: pseudo-random stretch
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], lfsr[5] & lfsr[6] & lfsr[7],
           lfsr[8], {12'd0, lfsr[11:8]}, {5'd0, lfsr[14:12]}, lfsr[15], "R4");
    end
    // R1: reset mid-window
    step(0, 1, 1, 0, 0, 16'd0, 8'd9, 0, "R1");
    step(1, 1, 0, 0, 0, 16'd0, 8'd9, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule